// File: doc/BRIEF.md
# Grouped Carry-Lookahead Adder

A combinational two-operand adder whose width is split into 4-bit slices. Inside each slice every carry is formed at once from per-bit generate and propagate terms, so a slice has no internal carry chain. Between slices the carry ripples: the carry-out of one slice is the carry-in of the next. With the default width of 16 there are four slices and three slice-to-slice hops on the critical path.

Each bit forms generate as the AND of its operand bits and propagate as their OR, and uses both to build the carries. The sum bit uses a separate XOR term of the operand bits, XORed with the incoming carry. Each slice also reports its own generate and propagate, so a later stage of lookahead across slices can be added without touching the slices.

The adder has no clock and no state. Its width is a parameter and must be a multiple of 4.

Top module: `grouped_cla_adder`

## Requirements
- R1: For every pair of operands and every carry-in value, `{carry_o, sum_o}` equals `a_i + b_i + carry_i` taken as a WIDTH+1 bit unsigned sum.
- R2: When a slice neither generates nor propagates, its carry-out is 0 whatever its carry-in. A slice then passes no carry into the slice above it.
- R3: `grp_gen_o[k]` covers operand bits `4k+3..4k`. It is 1 exactly when the two 4-bit slices sum to 16 or more with no carry-in, which means the slice produces a carry on its own.
- R4: `grp_prop_o[k]` covers operand bits `4k+3..4k`. It is 1 exactly when each of those four bit positions has at least one operand bit set, that is, when the OR of the two slices is 4'hF. It is also 1 when both operands have a bit set, such as a=b=4'hF.
- R5: The carry-in enters bit 0 of the lowest slice. With a=0, b=0 and carry_i=1, the sum is 1 and the carry-out is 0.
- R6: The carry out of slice k is the carry into slice k+1. With a=16'hFFFF, b=0 and carry_i=1, the carry passes through every slice, giving sum 0 and carry_o 1.
- R7: Each sum bit is the operand XOR combined with its carry, not the OR-based propagate. With a=b=16'h5555 and carry_i=0, the sum is 16'hAAAA.
- R8: `carry_o` is the carry out of the top bit. With a=b=16'h8000 and carry_i=0, the sum is 0 and carry_o is 1. The adder is purely combinational, so outputs follow a change of inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the top bit |
| grp_gen_o | output | WIDTH/4 | Per-slice generate, bit k for slice k |
| grp_prop_o | output | WIDTH/4 | Per-slice propagate, bit k for slice k |

## Verification
Assertions inside the RTL are re-evaluated whenever the inputs change. They check the following:
- the full sum against a plain addition;
- the carry relation between each pair of neighbouring slices;
- that a slice generate forces its carry-out;
- that propagate together with a carry-in forces the carry-out;
- that a slice with neither passes no carry.

The assertions cannot show that the slice flags have the exact meaning R3 and R4 give them. They also cannot show how particular operand patterns behave, such as full-width carry runs, equal operands that would expose an OR-for-XOR sum error, and the carry-in entry point. The bench covers these with directed cases, an exhaustive sweep of one 4-bit slice at both the low and top positions, and random full-width operands applied with both carry-in values.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W = 4;
endpackage

// File: rtl/cla_bitcell.sv
module cla_bitcell (
  input  logic a_i,
  input  logic b_i,
  output logic gen_o,
  output logic prop_o,
  output logic hsum_o
);
  assign gen_o  = a_i & b_i;
  assign prop_o = a_i | b_i;   // carry path only
  assign hsum_o = a_i ^ b_i;   // sum path only
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = GRP_W
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] cbit_o,   // carry into each bit
  output logic         cout_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [N-1:0] gterm;
  logic [N-1:0] pterm;

  // Fully expanded sum of products per carry, no chain between bits.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = i; j >= 0; j--) begin
        acc = acc | (gen_i[j] & run);
        run = run & prop_i[j];
      end
      gterm[i] = acc;
      pterm[i] = run;
    end
  end

  always_comb begin
    cbit_o[0] = cin_i;
    for (int i = 1; i < N; i++) cbit_o[i] = gterm[i-1] | (pterm[i-1] & cin_i);
  end

  assign grp_gen_o  = gterm[N-1];
  assign grp_prop_o = pterm[N-1];
  assign cout_o     = gterm[N-1] | (pterm[N-1] & cin_i);

  always_comb begin
    if (grp_gen_o) AST_GEN_FORCES_CARRY: assert (cout_o);                          // R3
    if (grp_prop_o && cin_i) AST_PROP_PASSES_CARRY: assert (cout_o);               // R4
    if (!grp_gen_o && !grp_prop_o) AST_NO_GEN_NO_PROP_KILLS: assert (!cout_o);     // R2
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] a_i,
  input  logic [GRP_W-1:0] b_i,
  input  logic             cin_i,
  output logic [GRP_W-1:0] sum_o,
  output logic             cout_o,
  output logic             grp_gen_o,
  output logic             grp_prop_o
);
  logic [GRP_W-1:0] gen, prop, hsum, cbit;

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    cla_bitcell u_cell (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .gen_o  (gen[i]),
      .prop_o (prop[i]),
      .hsum_o (hsum[i])
    );
  end

  cla_lookahead #(.N(GRP_W)) u_la (
    .gen_i      (gen),
    .prop_i     (prop),
    .cin_i      (cin_i),
    .cbit_o     (cbit),
    .cout_o     (cout_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  assign sum_o = hsum ^ cbit;

  always_comb begin
    AST_GROUP_SUM: assert ({cout_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{GRP_W{1'b0}}, cin_i}));                     // R7
  end
endmodule

// File: rtl/grouped_cla_adder.sv
module grouped_cla_adder
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0]       a_i,
  input  logic [WIDTH-1:0]       b_i,
  input  logic                   carry_i,
  output logic [WIDTH-1:0]       sum_o,
  output logic                   carry_o,
  output logic [WIDTH/GRP_W-1:0] grp_gen_o,
  output logic [WIDTH/GRP_W-1:0] grp_prop_o
);
  localparam int unsigned GROUPS = WIDTH / GRP_W;

  logic [GROUPS:0] gcarry;   // ripple between slices
  assign gcarry[0] = carry_i;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    cla_group u_grp (
      .a_i        (a_i[k*GRP_W +: GRP_W]),
      .b_i        (b_i[k*GRP_W +: GRP_W]),
      .cin_i      (gcarry[k]),
      .sum_o      (sum_o[k*GRP_W +: GRP_W]),
      .cout_o     (gcarry[k+1]),
      .grp_gen_o  (grp_gen_o[k]),
      .grp_prop_o (grp_prop_o[k])
    );
  end

  assign carry_o = gcarry[GROUPS];

  always_comb begin
    AST_FULL_SUM: assert ({carry_o, sum_o} ==
      ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}));                    // R1
    for (int k = 0; k < GROUPS; k++) begin
      AST_SLICE_CHAIN: assert (gcarry[k+1] == (grp_gen_o[k] | (grp_prop_o[k] & gcarry[k]))); // R6
    end
  end
endmodule

// File: tb/grouped_cla_adder_test.sv
module grouped_cla_adder_test;
  localparam int W = 16;
  localparam int G = W / 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [W-1:0] a, b, sum;
  logic cin, cout;
  logic [G-1:0] ggen, gprop;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  grouped_cla_adder #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .carry_i(cin),
    .sum_o(sum), .carry_o(cout),
    .grp_gen_o(ggen), .grp_prop_o(gprop)
  );

  function automatic logic [W:0] ref_sum(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [G-1:0] ref_gen(logic [W-1:0] x, logic [W-1:0] y);
    logic [G-1:0] r;
    for (int k = 0; k < G; k++) r[k] = ({1'b0, x[k*4 +: 4]} + {1'b0, y[k*4 +: 4]}) > 5'd15;
    return r;
  endfunction

  function automatic logic [G-1:0] ref_prop(logic [W-1:0] x, logic [W-1:0] y);
    logic [G-1:0] r;
    for (int k = 0; k < G; k++) r[k] = &(x[k*4 +: 4] | y[k*4 +: 4]);
    return r;
  endfunction

  task automatic apply(logic [W-1:0] x, logic [W-1:0] y, logic c);
    @(posedge clk);
    a = x; b = y; cin = c;
    @(negedge clk);
  endtask

  task automatic chk_sum(string req);
    logic [W:0] exp = ref_sum(a, b, cin);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h cin=%b: got %h expected %h", req, a, b, cin, {cout, sum}, exp);
    end
  endtask

  task automatic chk_flags();
    logic [G-1:0] eg = ref_gen(a, b);
    logic [G-1:0] ep = ref_prop(a, b);
    checks++;
    if (ggen !== eg) begin
      errors++;
      $display("FAIL R3 a=%h b=%h: grp_gen got %b expected %b", a, b, ggen, eg);
    end
    checks++;
    if (gprop !== ep) begin
      errors++;
      $display("FAIL R4 a=%h b=%h: grp_prop got %b expected %b", a, b, gprop, ep);
    end
  endtask

  task automatic chk_val(string req, logic [W:0] exp);
    checks++;
    if ({cout, sum} !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1BADC0DE));
    a = '0; b = '0; cin = 1'b0;
    @(negedge clk);
    chk_val("R1 zero inputs", 17'h0);
    chk_flags();

    // R5 carry-in enters bit 0
    apply('0, '0, 1'b1);
    chk_val("R5", 17'h00001);
    // R6 ripple through every slice
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk_val("R6", 17'h10000);
    chk_flags();
    // R7 XOR for sum, equal operands
    apply(16'h5555, 16'h5555, 1'b0);
    chk_val("R7", 17'h0AAAA);
    chk_flags();
    // R8 carry-out from top bit
    apply(16'h8000, 16'h8000, 1'b0);
    chk_val("R8", 17'h10000);
    // R2 kill slice stops carry
    apply(16'hF0FF, 16'h0001, 1'b0);
    chk_val("R2", 17'h0F100);
    chk_flags();
    // R4 propagate with both bits set
    apply(16'h000F, 16'h000F, 1'b1);
    chk_val("R4", 17'h0001F);
    chk_flags();
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    chk_sum("R1 all ones");

    // exhaustive single slice at low and top position
    for (int pos = 0; pos < 2; pos++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          for (int c = 0; c < 2; c++) begin
            logic [W-1:0] xa = (pos == 0) ? W'(x) : W'(x) << (W - 4);
            logic [W-1:0] yb = (pos == 0) ? W'(y) : W'(y) << (W - 4);
            apply(xa, yb, c[0]);
            chk_sum("R1 slice sweep");
            chk_flags();
          end
        end
      end
    end

    // random full width, both carry-in values
    for (int n = 0; n < 10000; n++) begin
      logic [W-1:0] ra = W'($urandom);
      logic [W-1:0] rb = W'($urandom);
      for (int c = 0; c < 2; c++) begin
        apply(ra, rb, c[0]);
        chk_sum("R1 random");
        if (n < 500) chk_flags();
      end
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule